// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point operands (1 sign bit, 8 exponent bits, 23 fraction bits, exponent bias 127). It produces the rounded product and four condition flags: overflow, underflow, not-a-number and zero. The arithmetic path is combinational. The product and the flags are captured in one output register, so every result is ready one clock edge after its operands are presented.

The result sign is the XOR of the operand signs. The stored exponents are added and the bias is removed once. The two 24-bit significands, each with its hidden one restored, are multiplied in full. Normalization takes two one-place right shifts, each of which adds one to the exponent. The first applies when the raw product reaches 2.0. The second applies when rounding to nearest even carries out of the significand. The range checks for overflow and underflow use the exponent after both shifts. Operands with a zero exponent field are treated as zero. Results below the normal range are flushed to a signed zero.

Top module: `spf_multiplier`

## Requirements
- R1: For every non-NaN result, bit 31 of the product equals the XOR of bit 31 of the two operands.
- R2: For two normal operands whose product is in range, the product's exponent field is ea + eb - 127 (plus the normalization increments), and its fraction is the rounded significand product.
- R3: When the 48-bit significand product is 2.0 or more, the significand is shifted right one place before rounding, and the exponent is incremented.
- R4: Rounding is to nearest, with ties to even. The round bit is the first product bit below the kept 24 bits, and the sticky bit is the OR of every product bit below the round bit.
- R5: When rounding carries out of the 24-bit significand, the result is shifted right one more place, the fraction becomes zero and the exponent is incremented again.
- R6: When the final biased exponent is 255 or more, the output is a signed infinity (exponent field all ones, fraction zero) and the overflow flag is 1. This includes overflow caused only by the rounding carry.
- R7: When the final biased exponent is 0 or less, the output is a signed zero and both the underflow flag and the zero flag are 1. An exponent of exactly 1 is a normal result with no flag.
- R8: When an operand has an exponent field of 0 (zero or denormal) and the other operand is finite, the output is a signed zero with the zero flag set and no other flag.
- R9: When either operand is a NaN (exponent all ones, fraction nonzero), or when infinity is multiplied by zero, the output is 0x7FC00000 and only the NaN flag is set.
- R10: When an infinity is multiplied by an infinity or by a nonzero finite operand, the output is a signed infinity with all flags clear.
- R11: Outputs are registered. A result appears after the first rising edge that samples its operands. A synchronous active-high reset clears the product and all flags to 0.
- R12: At most one of the overflow, underflow and NaN flags is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| prod_o | output | 32 | Registered product |
| ovf_o | output | 1 | Exponent overflow flag |
| unf_o | output | 1 | Exponent underflow flag |
| nan_o | output | 1 | Not-a-number flag |
| zero_o | output | 1 | Zero-result flag |

## Verification
Each product and its four flags are due exactly one rising edge after the operands are applied, with no further pipeline delay. The bench changes operands on a falling edge and compares the outputs on the next falling edge. This puts every comparison half a cycle away from the capturing edge. A directed check reads the outputs one time unit after new operands are applied, to confirm they still show the previous result until the edge. Reset is checked by comparing the outputs on the falling edge that follows a rising edge sampled with reset high.

// File: rtl/spfm_pkg.sv
package spfm_pkg;

  // Operand category, decoded from the exponent and fraction fields
  typedef enum logic [1:0] {
    CAT_ZERO = 2'd0,
    CAT_NORM = 2'd1,
    CAT_INF  = 2'd2,
    CAT_NAN  = 2'd3
  } op_cat_e;

  localparam int NUM_OPS = 2;

endpackage

// File: rtl/spfm_classify.sv
module spfm_classify
  import spfm_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W    = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0]     op_i,
  output op_cat_e          cat_o,
  output logic             sign_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [MAN_W:0]   sig_o
);

  logic [MAN_W-1:0] frac;
  logic             exp_zero;
  logic             exp_full;

  assign sign_o   = op_i[W-1];
  assign exp_o    = op_i[W-2 -: EXP_W];
  assign frac     = op_i[MAN_W-1:0];
  assign exp_zero = (exp_o == '0);
  assign exp_full = (exp_o == '1);

  // hidden one restored for normal operands only
  assign sig_o = {~exp_zero, frac};

  always_comb begin
    if (exp_zero)          cat_o = CAT_ZERO;
    else if (!exp_full)    cat_o = CAT_NORM;
    else if (frac == '0)   cat_o = CAT_INF;
    else                   cat_o = CAT_NAN;
  end

endmodule

// File: rtl/spfm_sig_round.sv
module spfm_sig_round #(
  parameter int MAN_W = 23,
  localparam int SIG_W  = MAN_W + 1,
  localparam int PROD_W = 2 * SIG_W
) (
  input  logic [SIG_W-1:0] sa_i,
  input  logic [SIG_W-1:0] sb_i,
  output logic [MAN_W-1:0] frac_o,
  output logic [1:0]       exp_inc_o
);

  logic [PROD_W-1:0] prod;
  logic              prod_hi;
  logic [SIG_W-1:0]  keep;
  logic              rnd_bit;
  logic              sticky;
  logic              bump;
  logic [SIG_W:0]    rounded;
  logic              rnd_carry;

  assign prod    = sa_i * sb_i;
  assign prod_hi = prod[PROD_W-1];

  // first normalize step: one-place right shift when product >= 2.0
  always_comb begin
    if (prod_hi) begin
      keep    = prod[PROD_W-1 -: SIG_W];
      rnd_bit = prod[PROD_W-1-SIG_W];
      sticky  = |prod[PROD_W-2-SIG_W:0];
    end else begin
      keep    = prod[PROD_W-2 -: SIG_W];
      rnd_bit = prod[PROD_W-2-SIG_W];
      sticky  = |prod[PROD_W-3-SIG_W:0];
    end
  end

  // nearest, ties to even
  assign bump      = rnd_bit & (sticky | keep[0]);
  assign rounded   = {1'b0, keep} + {{SIG_W{1'b0}}, bump};
  assign rnd_carry = rounded[SIG_W];

  // second normalize step: rounding carried out of the significand
  assign frac_o    = rnd_carry ? rounded[MAN_W:1] : rounded[MAN_W-1:0];
  assign exp_inc_o = {1'b0, prod_hi} + {1'b0, rnd_carry};

endmodule

// File: rtl/spfm_exp_eval.sv
module spfm_exp_eval #(
  parameter int EXP_W = 8,
  localparam int EW   = EXP_W + 3,
  localparam int BIAS = (1 << (EXP_W - 1)) - 1,
  localparam int EMAX = (1 << EXP_W) - 1
) (
  input  logic [EXP_W-1:0] ea_i,
  input  logic [EXP_W-1:0] eb_i,
  input  logic [1:0]       inc_i,
  output logic [EXP_W-1:0] exp_o,
  output logic             ovf_o,
  output logic             unf_o
);

  logic [EW-1:0]        sum;
  logic signed [EW-1:0] sum_s;

  assign sum   = EW'(ea_i) + EW'(eb_i) + EW'(inc_i) - EW'(BIAS);
  assign sum_s = $signed(sum);

  assign ovf_o = (sum_s >= EMAX);
  assign unf_o = (sum_s <= 0);
  assign exp_o = sum[EXP_W-1:0];

endmodule

// File: rtl/spf_multiplier.sv
module spf_multiplier
  import spfm_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [EXP_W+MAN_W:0]   a_i,
  input  logic [EXP_W+MAN_W:0]   b_i,
  output logic [EXP_W+MAN_W:0]   prod_o,
  output logic                   ovf_o,
  output logic                   unf_o,
  output logic                   nan_o,
  output logic                   zero_o
);

  localparam int W     = 1 + EXP_W + MAN_W;
  localparam int SIG_W = MAN_W + 1;
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {MAN_W{1'b0}}};

  logic [W-1:0]     ops   [NUM_OPS];
  op_cat_e          cat   [NUM_OPS];
  logic             sgn   [NUM_OPS];
  logic [EXP_W-1:0] expf  [NUM_OPS];
  logic [SIG_W-1:0] sig   [NUM_OPS];

  assign ops[0] = a_i;
  assign ops[1] = b_i;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_cls
    spfm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op_i   (ops[g]),
      .cat_o  (cat[g]),
      .sign_o (sgn[g]),
      .exp_o  (expf[g]),
      .sig_o  (sig[g])
    );
  end

  logic [MAN_W-1:0] frac_r;
  logic [1:0]       exp_inc;
  logic [EXP_W-1:0] exp_r;
  logic             rng_ovf;
  logic             rng_unf;

  spfm_sig_round #(.MAN_W(MAN_W)) u_sig (
    .sa_i      (sig[0]),
    .sb_i      (sig[1]),
    .frac_o    (frac_r),
    .exp_inc_o (exp_inc)
  );

  spfm_exp_eval #(.EXP_W(EXP_W)) u_exp (
    .ea_i  (expf[0]),
    .eb_i  (expf[1]),
    .inc_i (exp_inc),
    .exp_o (exp_r),
    .ovf_o (rng_ovf),
    .unf_o (rng_unf)
  );

  logic         sign_c;
  logic         any_nan, any_inf, any_zero;
  logic [W-1:0] res_c;
  logic         ovf_c, unf_c, nan_c, zero_c;

  assign sign_c   = sgn[0] ^ sgn[1];
  assign any_nan  = (cat[0] == CAT_NAN) || (cat[1] == CAT_NAN);
  assign any_inf  = (cat[0] == CAT_INF) || (cat[1] == CAT_INF);
  assign any_zero = (cat[0] == CAT_ZERO) || (cat[1] == CAT_ZERO);

  // priority: NaN, infinity, zero operand, range overflow, range underflow
  always_comb begin
    res_c  = {sign_c, exp_r, frac_r};
    ovf_c  = 1'b0;
    unf_c  = 1'b0;
    nan_c  = 1'b0;
    zero_c = 1'b0;
    if (any_nan || (any_inf && any_zero)) begin
      res_c = QNAN;
      nan_c = 1'b1;
    end else if (any_inf) begin
      res_c = {sign_c, INF_MAG};
    end else if (any_zero) begin
      res_c  = {sign_c, {(W-1){1'b0}}};
      zero_c = 1'b1;
    end else if (rng_ovf) begin
      res_c = {sign_c, INF_MAG};
      ovf_c = 1'b1;
    end else if (rng_unf) begin
      res_c  = {sign_c, {(W-1){1'b0}}};
      unf_c  = 1'b1;
      zero_c = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_o <= '0;
      ovf_o  <= 1'b0;
      unf_o  <= 1'b0;
      nan_o  <= 1'b0;
      zero_o <= 1'b0;
    end else begin
      prod_o <= res_c;
      ovf_o  <= ovf_c;
      unf_o  <= unf_c;
      nan_o  <= nan_c;
      zero_o <= zero_c;
    end
  end

  // R11: reset clears every output on the next edge
  a_r11_reset_clear: assert property (@(posedge clk)
    rst |=> (prod_o == '0 && !ovf_o && !unf_o && !nan_o && !zero_o));

  // R1: sign follows the XOR of the sampled operand signs
  a_r1_sign_xor: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (nan_o || prod_o[W-1] == ($past(a_i[W-1]) ^ $past(b_i[W-1]))));

  // R9: NaN flag always comes with the canonical quiet NaN
  a_r9_nan_canon: assert property (@(posedge clk) disable iff (rst)
    nan_o |-> (prod_o == QNAN && !zero_o));

  // R6: overflow flag always comes with an infinity
  a_r6_ovf_inf: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> (prod_o[W-2:0] == INF_MAG && !zero_o));

  // R7: underflow flag always comes with a flushed zero
  a_r7_unf_zero: assert property (@(posedge clk) disable iff (rst)
    unf_o |-> (prod_o[W-2:0] == '0 && zero_o));

  // R12: the exception flags never overlap
  a_r12_one_flag: assert property (@(posedge clk) disable iff (rst)
    $countones({ovf_o, unf_o, nan_o}) <= 1);

endmodule

// File: tb/sim_spf_multiplier.sv
module sim_spf_multiplier;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a = 32'h0;
  logic [31:0] b = 32'h0;
  logic [31:0] prod;
  logic        ovf, unf, nan, zero;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  spf_multiplier u0 (
    .clk    (clk),
    .rst    (rst),
    .a_i    (a),
    .b_i    (b),
    .prod_o (prod),
    .ovf_o  (ovf),
    .unf_o  (unf),
    .nan_o  (nan),
    .zero_o (zero)
  );

  // vector: {a, b, expected product, expected flags {ovf,unf,nan,zero}}
  localparam int NV = 24;
  localparam logic [99:0] VEC [NV] = '{
    {32'h3F800000, 32'h3F800000, 32'h3F800000, 4'h0},
    {32'h40000000, 32'h40400000, 32'h40C00000, 4'h0},
    {32'hBFC00000, 32'h40000000, 32'hC0400000, 4'h0},
    {32'hBF800000, 32'hBF800000, 32'h3F800000, 4'h0},
    {32'h3FC00000, 32'h3FC00000, 32'h40100000, 4'h0},
    {32'h3FFFFFFF, 32'h3F7FFFFF, 32'h3FFFFFFE, 4'h0},
    {32'h3F800001, 32'h3FFFFFFE, 32'h40000000, 4'h0},
    {32'h3F800001, 32'h3FC00000, 32'h3FC00002, 4'h0},
    {32'h3F800003, 32'h3FC00000, 32'h3FC00004, 4'h0},
    {32'h7F000000, 32'h40000000, 32'h7F800000, 4'h8},
    {32'hFF000000, 32'h40000000, 32'hFF800000, 4'h8},
    {32'h7F000001, 32'h3FFFFFFE, 32'h7F800000, 4'h8},
    {32'h7F000000, 32'h3FFFFFFF, 32'h7F7FFFFF, 4'h0},
    {32'h00800000, 32'h3F000000, 32'h00000000, 4'h5},
    {32'h80800000, 32'h3F000000, 32'h80000000, 4'h5},
    {32'h00800000, 32'h3F800000, 32'h00800000, 4'h0},
    {32'h00000000, 32'h40400000, 32'h00000000, 4'h1},
    {32'h80000000, 32'h40400000, 32'h80000000, 4'h1},
    {32'h00000001, 32'h3F800000, 32'h00000000, 4'h1},
    {32'h7FC00000, 32'h3F800000, 32'h7FC00000, 4'h2},
    {32'h7F800000, 32'h00000000, 32'h7FC00000, 4'h2},
    {32'h7F800001, 32'h3F800000, 32'h7FC00000, 4'h2},
    {32'h7F800000, 32'hC0000000, 32'hFF800000, 4'h0},
    {32'hFF800000, 32'hFF800000, 32'h7F800000, 4'h0}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 1:       return "R2";
      2, 3:       return "R1";
      4, 5:       return "R3";
      6:          return "R5";
      7, 8:       return "R4";
      9, 10, 11, 12: return "R6";
      13, 14, 15: return "R7";
      16, 17, 18: return "R8";
      19, 20, 21: return "R9";
      default:    return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] exp_p, logic [3:0] exp_f);
    n_chk++;
    if (prod !== exp_p || {ovf, unf, nan, zero} !== exp_f) begin
      n_fail++;
      $display("FAIL %s: got prod=%h flags=%b, expected prod=%h flags=%b",
               req, prod, {ovf, unf, nan, zero}, exp_p, exp_f);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got no completion, expected end of run");
    finish_run();
  end

  initial begin
    // R11: reset state with live operands applied
    a = 32'h40000000;
    b = 32'h40000000;
    @(negedge clk);
    @(negedge clk);
    check("R11", 32'h0, 4'h0);
    rst = 1'b0;

    // table walk: drive on falling edge, compare on the next falling edge
    for (int i = 0; i < NV; i++) begin
      a = VEC[i][99:68];
      b = VEC[i][67:36];
      @(negedge clk);
      check(tag_of(i), VEC[i][35:4], VEC[i][3:0]);
      // R12: no two of overflow, underflow, NaN together
      n_chk++;
      if ($countones({ovf, unf, nan}) > 1) begin
        n_fail++;
        $display("FAIL R12: got flags=%b, expected at most one exception flag",
                 {ovf, unf, nan});
      end
    end

    // R11: output holds until the capturing edge, then updates
    a = 32'h40000000;
    b = 32'h40000000;
    #1;
    check("R11", 32'h7F800000, 4'h0);
    @(negedge clk);
    check("R11", 32'h40800000, 4'h0);

    // R11: synchronous reset in mid-run clears outputs
    a = 32'h7F000000;
    rst = 1'b1;
    @(negedge clk);
    check("R11", 32'h0, 4'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R6", 32'h7F800000, 4'h8);

    // R8: zero times negative finite keeps XOR sign
    a = 32'h00000000;
    b = 32'hC0A00000;
    @(negedge clk);
    check("R8", 32'h80000000, 4'h1);

    // R9: NaN wins over a zero operand
    a = 32'h00000000;
    b = 32'hFFC00001;
    @(negedge clk);
    check("R9", 32'h7FC00000, 4'h2);

    finish_run();
  end

endmodule